// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block drives the read side of a flash-style memory during a synchronous burst. A start strobe, taken while the chip is enabled, loads a start address. After a programmable latency the block steps through consecutive addresses of a built-in word source and puts one data word on the output bus per beat. A beat lasts one or two clocks. A WAIT pin tells the host when the bus does not carry valid data. The pin's active level and its timing are both programmable.

A small configuration register sets the pin polarity, the beat length, whether WAIT leads the data by one beat, and the initial latency. Whenever the burst crosses a 16-word boundary, the block inserts one wait beat. Dropping chip enable stops the burst. The host must choose the two-clock beat whenever the clock period does not exceed the clock-to-data time plus the host's setup time.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration is polarity 1, two-clock beats, early WAIT and latency 3. The WAIT pin is at its inactive level (0) and `dout` is zero.
- R2: Configuration bit 0 sets the WAIT active level: 1 means active high and 0 means active low. The inactive level is the inverse.
- R3: Configuration bits 5:3 give the latency L in clocks. Codes 0 and 1 act as 2. Counting the cycle after the strobe edge as cycle 0, cycles 0 to L-1 carry no data and the first word appears in cycle L.
- R4: Configuration bit 1 selects beats of two clocks (1) or one clock (0). Each word is held for one beat. Addresses rise by one per word and wrap at the address width.
- R5: With configuration bit 2 set, the WAIT pin in each cycle shows the validity of the cycle one beat later. With bit 2 clear, it shows the current cycle.
- R6: After the word whose address has low four bits 1111, one beat without data is inserted before the next word.
- R7: In a cycle without valid data, `dout` is zero. In a cycle with valid data, it equals {addr, ~addr} for the current address.
- R8: When chip enable is low at a clock edge, the next cycle shows WAIT inactive and `dout` zero. A start strobe is ignored while chip enable is low. The burst does not resume without a new strobe.
- R9: A start strobe during a running burst restarts it from the new address with the full latency.
- R10: A pulse on `cfg_load` copies `cfg_word` into the configuration, and the new values apply from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| start | input | 1 | Burst start strobe |
| start_addr | input | AW | First address of the burst |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_word | input | 6 | Configuration value: {lat[2:0], early, hold2, pol} |
| dout | output | 2*AW | Data word, zero when not valid |
| wait_pin | output | 1 | WAIT output, polarity set by configuration |

## Verification
A wrong address count shows up as a wrong data word at the next valid beat, so it is visible within at most two clocks. A bad latency or phase count moves the first word, or the stretch of a beat, by whole clocks, and the WAIT pin or the data mismatches in that same cycle. A missing or extra boundary gap appears within 16 words as WAIT asserting in the wrong cycle and the data sequence slipping. Pin checks use all polarities, both beat lengths and both timings, so an inverted or mistimed WAIT is caught within one beat.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA, ST_GAP} bst_e;

  typedef struct packed {
    logic [2:0] lat;
    logic       early;
    logic       hold2;
    logic       pol;
  } bcfg_t;

  localparam int CFG_W = 6;
  localparam bcfg_t CFG_RESET = '{lat: 3'd3, early: 1'b1, hold2: 1'b1, pol: 1'b1};
endpackage

// File: rtl/bseq_cfg.sv
module bseq_cfg
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] word,
  output bcfg_t            cfg
);
  bcfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = bcfg_t'(word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg_q == bcfg_t'($past(word)))) else $error("cfg load"); // R10
endmodule

// File: rtl/bseq_core.sv
module bseq_core
  import bseq_pkg::*;
#(
  parameter int AW      = 8,
  parameter int BOUND_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  bcfg_t         cfg,
  output logic          c_act,
  output logic          c_inv,
  output logic [AW-1:0] c_addr
);
  bst_e          st_q, st_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          ph_q, ph_d;
  logic [2:0]    eff_l, lead;
  logic          beat_end, core_ce, at_top;

  assign eff_l    = (cfg.lat < 3'd2) ? 3'd2 : cfg.lat;
  assign lead     = cfg.hold2 ? (eff_l - 3'd2) : (eff_l - 3'd1);
  assign beat_end = cfg.hold2 ? ph_q : 1'b1;
  assign at_top   = &addr_q[BOUND_W-1:0];
  assign core_ce  = !en || start || (st_q != ST_IDLE);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    ph_d   = ph_q;
    if (!en) begin
      st_d = ST_IDLE;
      ph_d = 1'b0;
    end else if (start) begin
      addr_d = start_addr;
      ph_d   = 1'b0;
      if (lead == 3'd0) begin
        st_d = ST_DATA;
      end else begin
        st_d  = ST_LAT;
        cnt_d = lead - 3'd1;
      end
    end else begin
      case (st_q)
        ST_LAT: begin
          if (cnt_q == 3'd0) begin
            st_d = ST_DATA;
            ph_d = 1'b0;
          end else begin
            cnt_d = cnt_q - 3'd1;
          end
        end
        ST_DATA: begin
          if (beat_end) begin
            ph_d   = 1'b0;
            addr_d = addr_q + 1'b1;
            if (at_top) st_d = ST_GAP;
          end else begin
            ph_d = 1'b1;
          end
        end
        ST_GAP: begin
          if (beat_end) begin
            st_d = ST_DATA;
            ph_d = 1'b0;
          end else begin
            ph_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      ph_q   <= 1'b0;
    end else if (core_ce) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      ph_q   <= ph_d;
    end
  end

  assign c_act  = (st_q != ST_IDLE);
  assign c_inv  = (st_q == ST_LAT) || (st_q == ST_GAP);
  assign c_addr = addr_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && beat_end && en && !start) |=> (addr_q == $past(addr_q) + 1'b1))
    else $error("address step"); // R4
  AST_GAP_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && beat_end && at_top && en && !start) |=> (st_q == ST_GAP))
    else $error("gap missing"); // R6
  AST_GAP_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && beat_end && en && !start) |=> (st_q == ST_DATA))
    else $error("gap too long"); // R6
  AST_CE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == ST_IDLE)) else $error("ce stop"); // R8
endmodule

// File: rtl/bseq_out.sv
module bseq_out
  import bseq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start,
  input  logic            c_act,
  input  logic            c_inv,
  input  logic [AW-1:0]   c_addr,
  input  bcfg_t           cfg,
  output logic [2*AW-1:0] dout,
  output logic            wait_pin
);
  typedef struct packed {
    logic          act;
    logic          inv;
    logic [AW-1:0] addr;
  } stg_t;

  stg_t stg_q [DEPTH];
  stg_t stg_d [DEPTH];
  stg_t sel;
  logic asserted;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!en)        stg_d[i] = '0;
      else if (start) stg_d[i] = '{act: 1'b1, inv: 1'b1, addr: '0};
      else if (i == 0) stg_d[i] = '{act: c_act, inv: c_inv, addr: c_addr};
      else            stg_d[i] = stg_q[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_d[g];
    end
  end

  assign sel      = cfg.hold2 ? stg_q[1] : stg_q[0];
  assign asserted = cfg.early ? (c_act & c_inv) : (sel.act & sel.inv);
  assign wait_pin = cfg.pol ? asserted : ~asserted;
  assign dout     = (sel.act && !sel.inv) ? {sel.addr, ~sel.addr} : '0;

  AST_STRB_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start) |=> (dout == '0)) else $error("data after strobe"); // R3
  AST_CE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cfg_chg) |=> (dout == '0 && wait_pin == ~cfg.pol)) else $error("ce quiet"); // R8
  logic cfg_chg;
  assign cfg_chg = 1'b0;
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import bseq_pkg::*;
#(
  parameter int AW = 8,
  localparam int DW = 2 * AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  output logic [DW-1:0]    dout,
  output logic             wait_pin
);
  bcfg_t         cfg;
  logic          c_act, c_inv;
  logic [AW-1:0] c_addr;
  logic          strobe;

  assign strobe = start & chip_en;

  bseq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .word(cfg_word), .cfg(cfg)
  );

  bseq_core #(.AW(AW), .BOUND_W(4)) u_core (
    .clk(clk), .rst_n(rst_n), .en(chip_en), .start(strobe), .start_addr(start_addr),
    .cfg(cfg), .c_act(c_act), .c_inv(c_inv), .c_addr(c_addr)
  );

  bseq_out #(.AW(AW), .DEPTH(2)) u_out (
    .clk(clk), .rst_n(rst_n), .en(chip_en), .start(strobe), .c_act(c_act),
    .c_inv(c_inv), .c_addr(c_addr), .cfg(cfg), .dout(dout), .wait_pin(wait_pin)
  );

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !cfg_load) |=> (wait_pin == ~cfg.pol)) else $error("inactive level"); // R2
endmodule

// File: tb/sim_burst_read_seq.sv
module sim_burst_read_seq;
  localparam int  AW = 8;
  localparam time TCLK = 10ns;

  logic          clk, rst_n, chip_en, start, cfg_load;
  logic [AW-1:0] start_addr;
  logic [5:0]    cfg_word;
  logic [2*AW-1:0] dout;
  logic          wait_pin;

  int  errors = 0, checks = 0;
  bit  done = 0;
  bit  m_pol, m_h2, m_early;
  int  m_lat;

  burst_read_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start(start), .start_addr(start_addr),
    .cfg_load(cfg_load), .cfg_word(cfg_word), .dout(dout), .wait_pin(wait_pin)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  function automatic logic [2*AW-1:0] word_of(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  // Reference: state of output cycle k (k = 0 is the cycle after the strobe edge).
  function automatic void ref_state(input int k, input logic [AW-1:0] a0,
                                    output bit inv, output bit gap, output logic [AW-1:0] ad);
    int L, H, b;
    logic [AW-1:0] a;
    bit g;
    L = (m_lat < 2) ? 2 : m_lat;
    H = m_h2 ? 2 : 1;
    gap = 0;
    ad  = a0;
    if (k < L) begin
      inv = 1;
      return;
    end
    b = (k - L) / H;
    a = a0;
    g = 0;
    for (int j = 0; j < b; j++) begin
      if (g) g = 0;
      else begin
        if (a[3:0] == 4'hF) g = 1;
        a = a + 1'b1;
      end
    end
    inv = g;
    gap = g;
    ad  = a;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic load_cfg(input bit pol, input bit h2, input bit early, input int lat);
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_word = {3'(lat), early, h2, pol};
    @(negedge clk);
    cfg_load = 1'b0;
    m_pol = pol; m_h2 = h2; m_early = early; m_lat = lat;
  endtask

  task automatic run_burst(input logic [AW-1:0] a0, input int n, input string base);
    bit inv_now, inv_ahead, gap, exp_assert, exp_pin;
    logic [AW-1:0] ad, ad2;
    string tag;
    int L;
    L = (m_lat < 2) ? 2 : m_lat;
    @(negedge clk);
    start = 1'b1;
    start_addr = a0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      ref_state(k, a0, inv_now, gap, ad);
      ref_state(k + (m_h2 ? 2 : 1), a0, inv_ahead, gap, ad2);
      ref_state(k, a0, inv_now, gap, ad);
      exp_assert = m_early ? inv_ahead : inv_now;
      exp_pin = m_pol ? exp_assert : ~exp_assert;
      if (base != "") tag = base;
      else if (m_early) tag = "R5";
      else if (k < L) tag = "R3";
      else if (gap) tag = "R6";
      else tag = "R2";
      check(wait_pin == exp_pin, tag, $sformatf("wait k=%0d", k), 32'(wait_pin), 32'(exp_pin));
      if (inv_now)
        check(dout == '0, (base != "") ? base : "R7", $sformatf("dout idle k=%0d", k), 32'(dout), 0);
      else
        check(dout == word_of(ad), (base != "") ? base : "R4", $sformatf("dout k=%0d", k),
              32'(dout), 32'(word_of(ad)));
    end
  endtask

  task automatic ce_drop();
    @(negedge clk);
    chip_en = 1'b0;
    @(negedge clk);
    check(wait_pin == ~m_pol, "R8", "wait after ce drop", 32'(wait_pin), 32'(~m_pol));
    check(dout == '0, "R8", "dout after ce drop", 32'(dout), 0);
    start = 1'b1;
    start_addr = 8'h33;
    @(negedge clk);
    start = 1'b0;
    chip_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(wait_pin == ~m_pol, "R8", "wait stays idle", 32'(wait_pin), 32'(~m_pol));
      check(dout == '0, "R8", "dout stays idle", 32'(dout), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed, r;
    seed = 1234;
    r = $urandom(seed);
    rst_n = 1'b0; chip_en = 1'b0; start = 1'b0; cfg_load = 1'b0;
    start_addr = '0; cfg_word = '0;
    m_pol = 1; m_h2 = 1; m_early = 1; m_lat = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wait_pin == 1'b0, "R1", "reset wait level", 32'(wait_pin), 0);
    check(dout == '0, "R1", "reset dout", 32'(dout), 0);
    chip_en = 1'b1;
    @(negedge clk);
    run_burst(8'h0C, 40, "R1");
    ce_drop();

    load_cfg(0, 0, 0, 2);
    run_burst(8'hFD, 30, "");
    run_burst(8'h40, 12, "R9");
    load_cfg(1, 1, 0, 0);
    run_burst(8'h2E, 30, "");
    load_cfg(0, 1, 1, 7);
    run_burst(8'h0F, 30, "");
    load_cfg(1, 0, 1, 1);
    run_burst(8'h1E, 24, "");
    ce_drop();
    load_cfg(0, 0, 0, 5);
    run_burst(8'h5B, 10, "R10");

    for (int t = 0; t < 40; t++) begin
      bit p, h, e;
      int l, n;
      logic [AW-1:0] a;
      p = 1'($urandom);
      h = 1'($urandom);
      e = 1'($urandom);
      l = int'($urandom % 8);
      n = 10 + int'($urandom % 50);
      a = AW'($urandom);
      if (($urandom % 3) == 0) a[3:0] = 4'hE;
      load_cfg(p, h, e, l);
      run_burst(a, n, "");
      if (($urandom % 5) == 0) ce_drop();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule